// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Each lookup carries a per-page mode bit. In dynamic mode the block reads a history table that has no tags. The table is indexed by low bits of the branch address, and each entry holds the three most recent resolved outcomes of the branches that map to it. The guess is the majority of those three outcomes. In static mode the table is not consulted: a branch with a negative displacement (a backward branch) is guessed taken, and a forward branch is guessed not taken.

Resolved outcomes come back on a separate resolve port. A resolve that carries the dynamic mode bit shifts its entry's history by one place. A resolve from a static-mode page leaves the table alone. The lookup result is registered, so the guess appears one clock after the lookup is presented.

Top module: `maj_branch_predictor`

## Requirements
- R1: During and directly after a synchronous active-low reset, `pred_valid` is 0, and every history entry reads as three not-taken outcomes, so a dynamic lookup to any address predicts not taken.
- R2: `pred_valid` equals the `lk_valid` value presented one clock earlier. The prediction for a lookup appears in that same cycle.
- R3: In dynamic mode (`lk_dyn`=1), the prediction is taken exactly when at least two of the entry's three stored outcome bits are 1 (1 = taken).
- R4: The entry is selected by address bits [9:2], and no tag is compared. Two addresses that agree in bits [9:2] share one history.
- R5: A resolve with `rs_valid`=1 and `rs_dyn`=1 shifts the selected entry's history left by one place. `rs_taken` enters bit 0 and the oldest outcome in bit 2 is dropped.
- R6: A resolve with `rs_dyn`=0 leaves every history entry unchanged.
- R7: In static mode (`lk_dyn`=0), the prediction is taken when `lk_back`=1 (negative displacement) and not taken when `lk_back`=0, whatever the table holds.
- R8: When a lookup and a resolve to the same entry occur in the same cycle, the lookup uses the history as it stood before that resolve.
- R9: When `pred_valid` is 0, `pred_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | 32 | Address of the branch being looked up |
| lk_back | input | 1 | 1 when the branch displacement is negative (backward branch) |
| lk_dyn | input | 1 | Page mode of the lookup: 1 = dynamic, 0 = static |
| rs_valid | input | 1 | A resolved outcome is presented this cycle |
| rs_addr | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Resolved outcome: 1 = taken |
| rs_dyn | input | 1 | Page mode of the resolved branch: 1 = dynamic, 0 = static |
| pred_valid | output | 1 | Registered: a prediction is present |
| pred_taken | output | 1 | Registered: predicted direction, 1 = taken |

## Verification
A corrupted history entry stays hidden until a dynamic lookup reaches that index. It then shows as a flipped `pred_taken` one clock after the lookup, but only if the corruption changes the majority. A wrong bit can therefore stay masked across several lookups, until later resolves shift it into a position where it decides the vote. For this reason the bench keeps a full shadow history per index and compares every dynamic lookup. It sends its random traffic to a small set of aliasing addresses, so that each entry is shifted and read many times.

// File: rtl/mbp_pkg.sv
// Package: shared mode encoding and default sizes for the majority-vote
// branch predictor. Assumes nothing beyond IEEE 1800-2017.
package mbp_pkg;

    // Prediction mode carried with each instruction page.
    typedef enum logic {
        PM_STATIC  = 1'b0,
        PM_DYNAMIC = 1'b1
    } pmode_e;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_IDX_W   = 8;
    localparam int unsigned DEF_IDX_LSB = 2;
    localparam int unsigned DEF_HIST_W  = 3;

endpackage

// File: rtl/mbp_hist_table.sv
// Module: untagged outcome-history table.
// Holds 2**IDX_W shift histories of HIST_W bits each. The read port is
// combinational. A write shifts one entry left and inserts the new outcome at bit 0.
// Assumes HIST_W >= 2. A read and a write in the same cycle return the
// old contents, because the write lands at the clock edge.
module mbp_hist_table #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][HIST_W-1:0] hist_q;

    // Purpose: clear all histories on reset, shift in one outcome per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= {hist_q[wr_idx][HIST_W-2:0], wr_taken};
        end
    end

    // Purpose: present the addressed history to the vote logic.
    always_comb begin
        rd_hist = hist_q[rd_idx];
    end

    // R5: the new outcome lands in bit 0 of the written entry.
    assert_shift_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_taken));

    // R5: the older outcomes move up one place.
    assert_shift_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q[$past(wr_idx)][HIST_W-1:1] == $past(rd_hist_w));

    // R6: no write enable, no change anywhere in the table.
    assert_static_no_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hist_q));

    logic [HIST_W-2:0] rd_hist_w;
    // Purpose: low bits of the entry being written, used by the shift check.
    always_comb begin
        rd_hist_w = hist_q[wr_idx][HIST_W-2:0];
    end

endmodule

// File: rtl/mbp_majority.sv
// Module: majority vote over a history word.
// Returns taken when more than half of the HIST_W bits are 1. For the
// usual width of three, it uses the two-level pairwise form.
module mbp_majority #(
    parameter int unsigned HIST_W = 3
) (
    input  logic [HIST_W-1:0] hist,
    output logic              taken
);
    generate
        if (HIST_W == 3) begin : g_pairwise
            // Purpose: taken when any two of the three outcomes are taken.
            always_comb begin
                taken = (hist[0] & hist[1]) | (hist[1] & hist[2]) | (hist[0] & hist[2]);
            end
        end else begin : g_count
            // Purpose: population count against half the width.
            always_comb begin
                taken = ($countones(hist) > (HIST_W / 2));
            end
        end
    endgenerate

endmodule

// File: rtl/mbp_static_rule.sv
// Module: static direction rule.
// A negative displacement (backward, loop-closing branch) is guessed taken.
// A forward branch is guessed not taken.
module mbp_static_rule (
    input  logic backward,
    output logic taken
);
    // Purpose: direction follows the displacement sign.
    always_comb begin
        taken = backward;
    end

endmodule

// File: rtl/maj_branch_predictor.sv
// Module: top of the majority-vote branch direction predictor.
// Picks the static rule or the table vote according to the lookup's page
// mode, and registers the result, so that a prediction appears one clock
// after its lookup. Resolves from dynamic pages update the table.
// Assumes lookups and resolves may arrive in any cycle, independently of each other.
module maj_branch_predictor
    import mbp_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned IDX_W   = DEF_IDX_W,
    parameter int unsigned IDX_LSB = DEF_IDX_LSB,
    parameter int unsigned HIST_W  = DEF_HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_back,
    input  logic              lk_dyn,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    input  logic              rs_dyn,
    output logic              pred_valid,
    output logic              pred_taken
);
    pmode_e             lk_mode;
    pmode_e             rs_mode;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   rs_idx;
    logic [HIST_W-1:0]  lk_hist;
    logic               dyn_guess;
    logic               stat_guess;
    logic               upd_en;
    logic               guess;

    // Purpose: decode the mode bits and cut the index fields out of the addresses.
    always_comb begin
        lk_mode = pmode_e'(lk_dyn);
        rs_mode = pmode_e'(rs_dyn);
        lk_idx  = lk_addr[IDX_LSB +: IDX_W];
        rs_idx  = rs_addr[IDX_LSB +: IDX_W];
        upd_en  = rs_valid && (rs_mode == PM_DYNAMIC);
    end

    mbp_hist_table #(
        .IDX_W  (IDX_W),
        .HIST_W (HIST_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_hist  (lk_hist),
        .wr_en    (upd_en),
        .wr_idx   (rs_idx),
        .wr_taken (rs_taken)
    );

    mbp_majority #(
        .HIST_W (HIST_W)
    ) u_vote (
        .hist  (lk_hist),
        .taken (dyn_guess)
    );

    mbp_static_rule u_static (
        .backward (lk_back),
        .taken    (stat_guess)
    );

    // Purpose: choose between the two prediction sources by page mode.
    always_comb begin
        guess = (lk_mode == PM_DYNAMIC) ? dyn_guess : stat_guess;
    end

    // Purpose: register the prediction, forced low when no lookup was presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_taken <= 1'b0;
        end else begin
            pred_valid <= lk_valid;
            pred_taken <= lk_valid && guess;
        end
    end

    // R2: a lookup yields a valid prediction on the next clock.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid);

    // R2: no lookup, no prediction on the next clock.
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !pred_valid);

    // R7: in static mode the result tracks the displacement sign.
    assert_static_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_dyn) |=> (pred_taken == $past(lk_back)));

    // R9: no taken guess without a valid prediction.
    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_taken);

endmodule

// File: tb/maj_branch_predictor_tb.sv
// Bench: directed corner cases followed by seeded random traffic. Every
// prediction is compared against a shadow history model kept in the bench.
module maj_branch_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_back = 1'b0;
    logic        lk_dyn = 1'b0;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_addr = '0;
    logic        rs_taken = 1'b0;
    logic        rs_dyn = 1'b0;
    logic        pred_valid;
    logic        pred_taken;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [2:0] model [256];

    always #10 clk = ~clk;   // 50 MHz

    maj_branch_predictor u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .lk_back    (lk_back),
        .lk_dyn     (lk_dyn),
        .rs_valid   (rs_valid),
        .rs_addr    (rs_addr),
        .rs_taken   (rs_taken),
        .rs_dyn     (rs_dyn),
        .pred_valid (pred_valid),
        .pred_taken (pred_taken)
    );

    function automatic logic [7:0] idx_of(input logic [31:0] a);
        return a[9:2];
    endfunction

    function automatic logic vote(input logic [2:0] h);
        return (int'(h[0]) + int'(h[1]) + int'(h[2])) >= 2;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One cycle: drive at the falling edge, check after the next rising edge.
    task automatic step(input logic lv, input logic [31:0] la, input logic lb,
                        input logic ld, input logic rv, input logic [31:0] ra,
                        input logic rt, input logic rd, input string req);
        logic exp_t;
        lk_valid = lv; lk_addr = la; lk_back = lb; lk_dyn = ld;
        rs_valid = rv; rs_addr = ra; rs_taken = rt; rs_dyn = rd;
        exp_t = lv && (ld ? vote(model[idx_of(la)]) : lb);
        @(posedge clk);
        @(negedge clk);
        chk("R2 valid", pred_valid, lv);
        chk(req, pred_taken, exp_t);
        if (rv && rd) model[idx_of(ra)] = {model[idx_of(ra)][1:0], rt};
    endtask

    task automatic resolve(input logic [31:0] a, input logic t, input logic d);
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, a, t, d, "R9 idle");
    endtask

    task automatic look(input logic [31:0] a, input logic b, input logic d, input string req);
        step(1'b1, a, b, d, 1'b0, 32'h0, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        foreach (model[i]) model[i] = 3'b000;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", pred_valid, 1'b0);
        rst_n = 1'b1;
        chk("R1 valid after reset", pred_valid, 1'b0);
        // R1: cleared histories predict not taken
        look(32'h0000_0104, 1'b1, 1'b1, "R1 cleared entry");
        look(32'h0000_03FC, 1'b0, 1'b1, "R1 cleared entry top");
        // R5 and R3: T,T gives 011, which votes taken
        resolve(32'h0000_0040, 1'b1, 1'b1);
        look(32'h0000_0040, 1'b0, 1'b1, "R3 one taken");
        resolve(32'h0000_0040, 1'b1, 1'b1);
        look(32'h0000_0040, 1'b0, 1'b1, "R5 two taken");
        // R5: third taken, then two not-taken push the oldest taken out (100)
        resolve(32'h0000_0040, 1'b1, 1'b1);
        resolve(32'h0000_0040, 1'b0, 1'b1);
        look(32'h0000_0040, 1'b0, 1'b1, "R5 110");
        resolve(32'h0000_0040, 1'b0, 1'b1);
        look(32'h0000_0040, 1'b0, 1'b1, "R5 oldest dropped");
        // R4: alias in bit 10 shares the entry, a different index does not
        resolve(32'h0000_0480, 1'b1, 1'b1);
        resolve(32'h0000_0480, 1'b1, 1'b1);
        look(32'h0000_0080, 1'b0, 1'b1, "R4 alias shares");
        look(32'h0000_0084, 1'b0, 1'b1, "R4 neighbour untouched");
        // R6: static resolves leave the history unchanged
        resolve(32'h0000_0084, 1'b1, 1'b0);
        resolve(32'h0000_0084, 1'b1, 1'b0);
        look(32'h0000_0084, 1'b0, 1'b1, "R6 static resolve ignored");
        // R7: static direction ignores a taken-leaning table entry
        look(32'h0000_0080, 1'b0, 1'b0, "R7 forward");
        look(32'h0000_0080, 1'b1, 1'b0, "R7 backward");
        look(32'h0000_0084, 1'b1, 1'b0, "R7 backward cold");
        // R8: same-cycle resolve to the looked-up entry is not seen
        resolve(32'h0000_0100, 1'b1, 1'b1);
        step(1'b1, 32'h0000_0100, 1'b0, 1'b1, 1'b1, 32'h0000_0100, 1'b1, 1'b1, "R8 same cycle");
        look(32'h0000_0100, 1'b0, 1'b1, "R8 seen next cycle");
        // R9: idle cycle after a taken prediction reads as not taken
        step(1'b0, 32'h0000_0100, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, "R9 idle quiet");
        // Random traffic on a small aliasing address pool
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] la, ra;
            logic ld;
            la = $urandom & 32'h0000_0C1C;
            ra = $urandom & 32'h0000_0C1C;
            ld = ($urandom_range(0, 3) != 0);
            step($urandom_range(0, 3) != 0, la, $urandom_range(0, 1) == 1, ld,
                 $urandom_range(0, 2) != 0, ra, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 4) != 0, ld ? "R3 random" : "R7 random");
        end
        finish_run();
    end

endmodule